// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block brings a panel's four output stages up and down in a safe order: the pixel clock, the horizontal/vertical sync outputs, the display-enable output and the backlight PWM. Software controls the stages through two write-only command words. One word switches stages on and the other switches them off. Only the bits set to 1 act, so one stage can change without a read-modify-write. Software reads back a status word and polls each stage until it reaches the state it asked for.

The block enforces the ordering that matters to the panel. Sync can only start while the pixel clock runs. Sync and display change state only on a frame-start pulse from the timing generator, so a partial frame is never driven. Display waits a guard time after sync starts. The guard time is counted in frames and is set by the parameter `GUARD_FRAMES`, default 1. Pixel clock and PWM follow their commands directly. Producing the video timing and the PWM waveform belongs to other blocks.

Top module: `lps_top`

## Requirements
- R1: Reset clears all four stage outputs, the status word and every pending request to off.
- R2: The stage bits in both command words are bit 0 pixel clock, bit 1 sync, bit 2 display and bit 3 PWM. A write with `cmd_off`=0 and bit 0 set turns the pixel clock on in the next cycle. A write with `cmd_off`=1 and bit 0 set turns it off in the next cycle.
- R3: Command bits written as 0 leave their stage unchanged. This holds in both command words, including a write whose data is all zero.
- R4: Sync turns on only on a cycle with `frame_start` high, and only while the sync request is held and the pixel clock is on.
- R5: A sync enable issued while the pixel clock is off stays pending. Sync turns on at the first `frame_start` after the clock comes on.
- R6: When the pixel clock is off, sync and display are both off from the following cycle on.
- R7: Display turns on at a `frame_start` only after sync has been on for `GUARD_FRAMES` full frames, counted in `frame_start` pulses seen while sync is on.
- R8: A display disable or a sync disable takes effect at the next `frame_start`. When sync drops, display drops in the same cycle. A display request left pending comes back after a new guard time.
- R9: PWM turns on or off in the cycle after its enable or disable command, whatever state the other stages are in.
- R10: `stat_rd` shows the four stage states, using the same bit positions as the command words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_we | input | 1 | Command write strobe |
| cmd_off | input | 1 | 0 selects the enable word, 1 selects the disable word |
| cmd_data | input | 4 | One bit per stage: 0 pixel clock, 1 sync, 2 display, 3 PWM |
| frame_start | input | 1 | One-cycle pulse at each frame boundary |
| stat_rd | output | 4 | Stage status, same bit layout as `cmd_data` |
| pclk_en | output | 1 | Pixel clock stage active |
| sync_en | output | 1 | Sync stage active |
| disp_en | output | 1 | Display stage active |
| pwm_en | output | 1 | PWM stage active |

## Verification
A command write and a `frame_start` pulse can fall in the same cycle. The test that matters most is a disable or enable of sync or display landing exactly on a frame boundary: the pulse must act on the request held before that write. A pixel-clock disable can also land on the frame boundary where sync would otherwise have risen. The bench provokes both cases with directed sequences and with a long run of random writes and random frame pulses. A behavioural model tracks each request, each stage and a frame count since sync started, and it judges every cycle.

// File: rtl/lps_pkg.sv
package lps_pkg;

    localparam int STAGES = 4;

    localparam int IDX_PCLK = 0;
    localparam int IDX_SYNC = 1;
    localparam int IDX_DISP = 2;
    localparam int IDX_PWM  = 3;

    typedef struct packed {
        logic pwm;
        logic disp;
        logic sync;
        logic pclk;
    } stage_vec_t;

    typedef enum logic {
        CMD_ON  = 1'b0,
        CMD_OFF = 1'b1
    } cmd_kind_e;

    function automatic stage_vec_t pack_stages(input logic pclk, input logic sync,
                                               input logic disp, input logic pwm);
        stage_vec_t v;
        v.pclk = pclk;
        v.sync = sync;
        v.disp = disp;
        v.pwm  = pwm;
        return v;
    endfunction

endpackage

// File: rtl/lps_cmd_dec.sv
module lps_cmd_dec
    import lps_pkg::*;
#(
    parameter int W = STAGES
) (
    input  logic         we_i,
    input  cmd_kind_e    kind_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] set_o,
    output logic [W-1:0] clr_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign set_o[i] = we_i && (kind_i == CMD_ON)  && data_i[i];
        assign clr_o[i] = we_i && (kind_i == CMD_OFF) && data_i[i];
    end

endmodule

// File: rtl/lps_req_bank.sv
module lps_req_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] req_o
);

    for (genvar i = 0; i < W; i++) begin : g_req
        always_ff @(posedge clk) begin
            if (rst)           req_o[i] <= 1'b0;
            else if (set_i[i]) req_o[i] <= 1'b1;
            else if (clr_i[i]) req_o[i] <= 1'b0;
        end

        // R9
        set_takes_chk: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> req_o[i]);
        // R9
        clr_takes_chk: assert property (@(posedge clk) disable iff (rst)
            (clr_i[i] && !set_i[i]) |=> !req_o[i]);
        // R3
        idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!set_i[i] && !clr_i[i]) |=> $stable(req_o[i]));
    end

endmodule

// File: rtl/lps_frame_stage.sv
module lps_frame_stage #(
    parameter int GUARD_FRAMES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_start,
    input  logic clk_on,
    input  logic sync_req,
    input  logic disp_req,
    output logic sync_on,
    output logic disp_on
);

    localparam int CW = $clog2(GUARD_FRAMES + 2);

    logic [CW-1:0] gcnt, gcnt_nx;
    logic [CW:0]   gcnt_inc;
    logic          guard_ok, sync_nx, disp_nx;

    always_comb begin
        gcnt_inc = {1'b0, gcnt} + 1'b1;
        guard_ok = frame_start && sync_on && (gcnt_inc >= (CW+1)'(GUARD_FRAMES));

        if (!clk_on)          sync_nx = 1'b0;
        else if (frame_start) sync_nx = sync_req;
        else                  sync_nx = sync_on;

        if (!sync_nx)         disp_nx = 1'b0;
        else if (frame_start) disp_nx = disp_req && (disp_on || guard_ok);
        else                  disp_nx = disp_on;

        if (!sync_nx)
            gcnt_nx = '0;
        else if (frame_start && sync_on && (gcnt < CW'(GUARD_FRAMES)))
            gcnt_nx = gcnt_inc[CW-1:0];
        else
            gcnt_nx = gcnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_on <= 1'b0;
            disp_on <= 1'b0;
            gcnt    <= '0;
        end else begin
            sync_on <= sync_nx;
            disp_on <= disp_nx;
            gcnt    <= gcnt_nx;
        end
    end

    // R4
    sync_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_on) |-> ($past(frame_start) && $past(clk_on) && $past(sync_req)));
    // R7
    disp_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(disp_on) |-> ($past(frame_start) && $past(sync_on) && $past(disp_req)));
    // R6
    clk_off_chk: assert property (@(posedge clk) disable iff (rst)
        !clk_on |=> (!sync_on && !disp_on));
    // R8
    sync_fall_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(sync_on) && $past(clk_on)) |-> $past(frame_start));

endmodule

// File: rtl/lps_top.sv
module lps_top
    import lps_pkg::*;
#(
    parameter int GUARD_FRAMES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic              cmd_off,
    input  logic [STAGES-1:0] cmd_data,
    input  logic              frame_start,
    output logic [STAGES-1:0] stat_rd,
    output logic              pclk_en,
    output logic              sync_en,
    output logic              disp_en,
    output logic              pwm_en
);

    logic [STAGES-1:0] set_v, clr_v, req_v;
    logic              sync_on, disp_on;
    stage_vec_t        status;
    cmd_kind_e         kind;

    assign kind = cmd_off ? CMD_OFF : CMD_ON;

    lps_cmd_dec #(.W(STAGES)) u_dec (
        .we_i   (cmd_we),
        .kind_i (kind),
        .data_i (cmd_data),
        .set_o  (set_v),
        .clr_o  (clr_v)
    );

    lps_req_bank #(.W(STAGES)) u_req (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_v),
        .clr_i (clr_v),
        .req_o (req_v)
    );

    lps_frame_stage #(.GUARD_FRAMES(GUARD_FRAMES)) u_frame (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .clk_on      (req_v[IDX_PCLK]),
        .sync_req    (req_v[IDX_SYNC]),
        .disp_req    (req_v[IDX_DISP]),
        .sync_on     (sync_on),
        .disp_on     (disp_on)
    );

    assign status  = pack_stages(req_v[IDX_PCLK], sync_on, disp_on, req_v[IDX_PWM]);
    assign stat_rd = status;
    assign pclk_en = status.pclk;
    assign sync_en = status.sync;
    assign disp_en = status.disp;
    assign pwm_en  = status.pwm;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (stat_rd == '0));
    // R8
    disp_needs_sync_chk: assert property (@(posedge clk) disable iff (rst)
        disp_en |-> sync_en);
    // R4
    sync_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(sync_en)) |-> $past(pclk_en));

endmodule

// File: tb/lps_top_tb.sv
module lps_top_tb;

    localparam int G = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_we = 1'b0;
    logic       cmd_off = 1'b0;
    logic [3:0] cmd_data = 4'h0;
    logic       frame_start = 1'b0;
    logic [3:0] stat_rd;
    logic       pclk_en, sync_en, disp_en, pwm_en;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // behavioural reference state
    bit m_clk, m_sreq, m_sync, m_dreq, m_disp, m_pwm;
    int m_frames;

    always #5 clk = ~clk;

    lps_top #(.GUARD_FRAMES(G)) u_dut (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_off(cmd_off),
        .cmd_data(cmd_data), .frame_start(frame_start), .stat_rd(stat_rd),
        .pclk_en(pclk_en), .sync_en(sync_en), .disp_en(disp_en), .pwm_en(pwm_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // reference update and per-cycle comparison
    always @(posedge clk) begin
        bit n_clk, n_sreq, n_dreq, n_pwm, n_sync, n_disp, g_ok;
        int n_frames;
        if (rst) begin
            n_clk = 0; n_sreq = 0; n_dreq = 0; n_pwm = 0; n_sync = 0; n_disp = 0;
            n_frames = 0;
        end else begin
            n_clk = m_clk; n_sreq = m_sreq; n_dreq = m_dreq; n_pwm = m_pwm;
            if (cmd_we) begin
                if (cmd_data[0]) n_clk  = !cmd_off;
                if (cmd_data[1]) n_sreq = !cmd_off;
                if (cmd_data[2]) n_dreq = !cmd_off;
                if (cmd_data[3]) n_pwm  = !cmd_off;
            end
            if (!m_clk) n_sync = 0;
            else if (frame_start) n_sync = m_sreq;
            else n_sync = m_sync;
            g_ok = frame_start && m_sync && (m_frames + 1 >= G);
            if (!n_sync) n_disp = 0;
            else if (frame_start) n_disp = m_dreq && (m_disp || g_ok);
            else n_disp = m_disp;
            if (!n_sync) n_frames = 0;
            else if (frame_start && m_sync) n_frames = m_frames + 1;
            else n_frames = m_frames;
        end
        m_clk = n_clk; m_sreq = n_sreq; m_dreq = n_dreq; m_pwm = n_pwm;
        m_sync = n_sync; m_disp = n_disp; m_frames = n_frames;
        #2;
        if (!done) begin
            chk(pclk_en == m_clk,  "R2 pclk_en",  pclk_en, m_clk);
            chk(sync_en == m_sync, "R4 sync_en",  sync_en, m_sync);
            chk(disp_en == m_disp, "R7 disp_en",  disp_en, m_disp);
            chk(pwm_en  == m_pwm,  "R9 pwm_en",   pwm_en,  m_pwm);
            chk(stat_rd == {m_pwm, m_disp, m_sync, m_clk}, "R10 stat_rd",
                stat_rd, {m_pwm, m_disp, m_sync, m_clk});
        end
    end

    task automatic wr(input bit off, input logic [3:0] d, input bit fs);
        @(negedge clk);
        cmd_we = 1'b1; cmd_off = off; cmd_data = d; frame_start = fs;
        @(negedge clk);
        cmd_we = 1'b0; cmd_data = 4'h0; frame_start = 1'b0;
    endtask

    task automatic fs_pulse();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk) rst = 1'b0;
        chk(stat_rd == 4'h0, "R1 reset status", stat_rd, 0);

        // sync enable with the clock off is held
        wr(0, 4'b0010, 0);
        fs_pulse(); fs_pulse(); fs_pulse();
        chk(sync_en == 1'b0, "R5 pending sync", sync_en, 0);
        wr(0, 4'b0001, 0);
        chk(pclk_en == 1'b1, "R2 clock on", pclk_en, 1);
        chk(sync_en == 1'b0, "R4 no frame yet", sync_en, 0);
        idle(2);
        fs_pulse();
        chk(sync_en == 1'b1, "R5 sync after clock", sync_en, 1);

        // guard time
        wr(0, 4'b0100, 0);
        fs_pulse();
        chk(disp_en == 1'b0, "R7 guard not elapsed", disp_en, 0);
        fs_pulse();
        chk(disp_en == 1'b1, "R7 guard elapsed", disp_en, 1);
        wr(0, 4'b1000, 0);
        chk(pwm_en == 1'b1, "R9 pwm on", pwm_en, 1);

        // zero writes do nothing
        wr(0, 4'b0000, 1);
        wr(1, 4'b0000, 1);
        chk(stat_rd == 4'hF, "R3 zero data", stat_rd, 4'hF);

        // display disable waits for a frame
        wr(1, 4'b0100, 0);
        idle(3);
        chk(disp_en == 1'b1, "R8 disp held mid-frame", disp_en, 1);
        fs_pulse();
        chk(disp_en == 1'b0, "R8 disp off at frame", disp_en, 0);

        // sync disable on the frame boundary takes display with it
        wr(0, 4'b0100, 0);
        fs_pulse(); fs_pulse();
        chk(disp_en == 1'b1, "R8 disp back", disp_en, 1);
        wr(1, 4'b0010, 0);
        fs_pulse();
        chk(stat_rd == 4'b1001, "R8 sync drop", stat_rd, 4'b1001);
        wr(0, 4'b0010, 1);
        fs_pulse();
        chk(sync_en == 1'b1, "R4 sync on", sync_en, 1);
        chk(disp_en == 1'b0, "R8 new guard", disp_en, 0);
        fs_pulse(); fs_pulse();
        chk(disp_en == 1'b1, "R8 pending disp returns", disp_en, 1);

        // clock off while running
        wr(1, 4'b0001, 1);
        chk(pclk_en == 1'b0, "R2 clock off", pclk_en, 0);
        idle(1);
        chk(sync_en == 1'b0 && disp_en == 1'b0, "R6 forced off",
            {sync_en, disp_en}, 0);
        wr(1, 4'b1000, 0);
        chk(pwm_en == 1'b0, "R9 pwm off", pwm_en, 0);

        // random mix of writes and frame pulses
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            cmd_we      = ($urandom % 4) == 0;
            cmd_off     = $urandom % 2;
            cmd_data    = 4'($urandom);
            frame_start = ($urandom % 5) == 0;
        end
        @(negedge clk);
        cmd_we = 1'b0; frame_start = 1'b0;

        // reset mid-run
        rst = 1'b1;
        idle(2);
        chk(stat_rd == 4'h0, "R1 reset again", stat_rd, 0);
        rst = 1'b0;
        idle(2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule